// File: doc/BRIEF.md
# Bus Region Decoder with Unaligned Load Rotation

This block sits between a processor's load/store unit and a set of on-chip and off-chip memories. For each access it takes bits [27:24] of the address as a region code, picks one target memory, and trims the address to that memory's mirrored window. Memories return one aligned 32-bit word, or two 16-bit halves for the I/O register file. The block then shifts and rotates that word into the value that the access size and the low address bits call for.

On stores it makes the byte-lane enables and a copy of the store data for each lane. It also applies the write rules of each region. Stores to read-only images are dropped. Byte stores to object RAM are dropped. A byte store into the low part of video RAM fills both bytes of its halfword.

The boot ROM is guarded. Its contents are visible only while the program counter region is the boot ROM itself. At all other times a boot ROM read returns a word latched from the instruction fetch stream during the last cycle of execution inside the boot ROM.

Top module: `bus_region_steer`

## Requirements
- R1: With `acc_valid` high, `region_sel` has at most one bit set. The bits are: 0 boot ROM (code 0), 1 work RAM (code 2), 2 internal RAM (code 3), 3 I/O (code 4), 4 palette (code 5), 5 video RAM (code 6), 6 object RAM (code 7), 7 ROM (codes 8 to 13). With `acc_valid` low, `region_sel` and `byte_we` are zero.
- R2: `region_off` is addr[24:0] ANDed with a mask for the region: boot 16 KiB−1, work RAM 256 KiB−1, internal RAM 32 KiB−1, I/O, palette and object RAM each 1 KiB−1, video RAM 0x1FFFF, ROM all 25 bits. Codes 8, 10 and 12 therefore reach the same ROM offsets.
- R3: A word read (size 2; size 3 acts the same) returns the aligned word rotated right by 8 × addr[1:0].
- R4: A halfword read (size 1) takes the half chosen by addr[1]. If addr[0] is set, it swaps the two bytes of that half. The upper 16 bits are zero.
- R5: A byte read (size 0) returns byte lane addr[1:0] of the aligned word, zero-extended.
- R6: A boot ROM read while `pc_region` is 0 returns memory data when addr[23:0] < 16384. Beyond that it returns 0 and selects nothing. While `pc_region` is not 0 it returns the latched word, with the lane rules applied, and selects nothing.
- R7: The latch takes `boot_fetch_word` on every clock edge where `pc_region` is 0. It holds while `pc_region` is anything else. Reset clears it to 0.
- R8: A ROM read whose `region_off` is at or above `rom_size` returns 0 and selects nothing.
- R9: `io_off_lo` is the I/O offset with bits [1:0] cleared. `io_off_hi` is the same offset with bit 1 set. An I/O read works on the word {`io_rdata_hi`, `io_rdata_lo`} under the R3 to R5 rules.
- R10: Codes 1, 14 and 15 are unmapped. A read there raises `rd_err` and returns 0. Any access there selects nothing and enables no lane. `region_off` is 0.
- R11: `wr_data` repeats the byte four times (size 0) or the halfword twice (size 1), or passes the word (size 2). Lane enables are 1<<addr[1:0] (byte), 0011 or 1100 by addr[1] (half), or 1111 (word). A store selects its target exactly when some lane is enabled.
- R12: A byte store to video RAM with addr[23:0] < 0x18000 enables both lanes of the halfword chosen by addr[1]. At or above 0x18000 it is dropped.
- R13: Stores to boot ROM or ROM, and byte stores to object RAM, enable no lane and select nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Byte address |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| acc_write | input | 1 | 1 store, 0 load |
| acc_wdata | input | 32 | Store data, low-aligned |
| pc_region | input | 4 | Region code of the current program counter |
| boot_fetch_word | input | 32 | Word on the boot ROM fetch path |
| rom_size | input | 26 | Loaded ROM image size in bytes |
| mem_rdata | input | 32 | Aligned word from the selected memory |
| io_rdata_lo | input | 16 | I/O register at `io_off_lo` |
| io_rdata_hi | input | 16 | I/O register at `io_off_hi` |
| region_sel | output | 8 | One-hot target select |
| region_off | output | 25 | Masked byte offset inside the target |
| io_off_lo | output | 10 | Low-half I/O register offset |
| io_off_hi | output | 10 | High-half I/O register offset |
| byte_we | output | 4 | Byte-lane write enables |
| wr_data | output | 32 | Lane-replicated store data |
| rd_data | output | 32 | Rotated, zero-extended load data |
| rd_err | output | 1 | Load from an unmapped region |

## Verification
The sweep covers every region code with each access size and each of the four low address offsets. It uses four offsets inside each region: one low address, one that crosses the mirror masks and the boot ROM end, and one on each side of the video RAM byte-store limit. The memories return a value that depends on target and word offset, so a wrong region, mask or rotation shows up as a different value. Read and write expectations are worked out from the stated lane and rotation rules.

A separate sequence moves the program counter region in and out of the boot ROM while the fetch word changes. This tells apart capture during boot execution, holding outside it, and the cleared state after reset.

// File: rtl/brs_pkg.sv
package brs_pkg;

    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int CODE_W   = 4;
    localparam int OFF_W    = 25;
    localparam int NUM_TGT  = 8;
    localparam int LANES    = DATA_W / 8;

    localparam logic [CODE_W-1:0] CODE_BOOT     = 4'h0;
    localparam logic [CODE_W-1:0] CODE_WRAM     = 4'h2;
    localparam logic [CODE_W-1:0] CODE_IRAM     = 4'h3;
    localparam logic [CODE_W-1:0] CODE_IO       = 4'h4;
    localparam logic [CODE_W-1:0] CODE_PAL      = 4'h5;
    localparam logic [CODE_W-1:0] CODE_VRAM     = 4'h6;
    localparam logic [CODE_W-1:0] CODE_OAM      = 4'h7;
    localparam logic [CODE_W-1:0] CODE_ROM_LO   = 4'h8;
    localparam logic [CODE_W-1:0] CODE_ROM_HI   = 4'hD;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        TGT_BOOT = 3'd0,
        TGT_WRAM = 3'd1,
        TGT_IRAM = 3'd2,
        TGT_IO   = 3'd3,
        TGT_PAL  = 3'd4,
        TGT_VRAM = 3'd5,
        TGT_OAM  = 3'd6,
        TGT_ROM  = 3'd7
    } tgt_e;

    typedef struct packed {
        logic             mapped;
        tgt_e             tgt;
        logic [OFF_W-1:0] off;
    } decode_t;

    // Rotate a word right by whole bytes.
    function automatic logic [DATA_W-1:0] ror_bytes(input logic [DATA_W-1:0] w,
                                                    input logic [1:0] n);
        case (n)
            2'd0:    ror_bytes = w;
            2'd1:    ror_bytes = {w[7:0],  w[31:8]};
            2'd2:    ror_bytes = {w[15:0], w[31:16]};
            default: ror_bytes = {w[23:0], w[31:24]};
        endcase
    endfunction

    // Turn an aligned word into the value a load of the given size returns.
    function automatic logic [DATA_W-1:0] load_extract(input logic [DATA_W-1:0] w,
                                                       input acc_size_e sz,
                                                       input logic [1:0] lo);
        logic [DATA_W-1:0] r;
        logic [15:0]       h;
        r = ror_bytes(w, lo);
        h = lo[1] ? w[31:16] : w[15:0];
        if (lo[0]) h = {h[7:0], h[15:8]};
        case (sz)
            SZ_BYTE: load_extract = {24'b0, r[7:0]};
            SZ_HALF: load_extract = {16'b0, h};
            default: load_extract = r;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] store_replicate(input logic [DATA_W-1:0] w,
                                                          input acc_size_e sz);
        case (sz)
            SZ_BYTE: store_replicate = {4{w[7:0]}};
            SZ_HALF: store_replicate = {2{w[15:0]}};
            default: store_replicate = w;
        endcase
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input acc_size_e sz,
                                                   input logic [1:0] lo);
        case (sz)
            SZ_BYTE: lane_mask = 4'b0001 << lo;
            SZ_HALF: lane_mask = lo[1] ? 4'b1100 : 4'b0011;
            default: lane_mask = 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/brs_region_decode.sv
module brs_region_decode
    import brs_pkg::*;
#(
    parameter int BOOT_BYTES      = 16384,
    parameter int WRAM_BYTES      = 262144,
    parameter int IRAM_BYTES      = 32768,
    parameter int IO_BYTES        = 1024,
    parameter int PAL_BYTES       = 1024,
    parameter int VRAM_WINDOW     = 131072,
    parameter int OAM_BYTES       = 1024,
    parameter int VRAM_BYTE_LIMIT = 98304
) (
    input  logic [27:0] addr_in,
    output decode_t     dec,
    output logic        boot_in_bounds,
    output logic        vram_byte_ok
);

    localparam logic [OFF_W-1:0] M_BOOT = OFF_W'(BOOT_BYTES - 1);
    localparam logic [OFF_W-1:0] M_WRAM = OFF_W'(WRAM_BYTES - 1);
    localparam logic [OFF_W-1:0] M_IRAM = OFF_W'(IRAM_BYTES - 1);
    localparam logic [OFF_W-1:0] M_IO   = OFF_W'(IO_BYTES - 1);
    localparam logic [OFF_W-1:0] M_PAL  = OFF_W'(PAL_BYTES - 1);
    localparam logic [OFF_W-1:0] M_VRAM = OFF_W'(VRAM_WINDOW - 1);
    localparam logic [OFF_W-1:0] M_OAM  = OFF_W'(OAM_BYTES - 1);
    localparam logic [OFF_W-1:0] M_ROM  = {OFF_W{1'b1}};

    logic [CODE_W-1:0] code;
    logic [OFF_W-1:0]  raw;

    always_comb begin
        code       = addr_in[27:24];
        raw        = addr_in[24:0];
        dec.mapped = 1'b1;
        dec.tgt    = TGT_BOOT;
        dec.off    = '0;
        if (code >= CODE_ROM_LO && code <= CODE_ROM_HI) begin
            dec.tgt = TGT_ROM;
            dec.off = raw & M_ROM;
        end else begin
            case (code)
                CODE_BOOT: begin dec.tgt = TGT_BOOT; dec.off = raw & M_BOOT; end
                CODE_WRAM: begin dec.tgt = TGT_WRAM; dec.off = raw & M_WRAM; end
                CODE_IRAM: begin dec.tgt = TGT_IRAM; dec.off = raw & M_IRAM; end
                CODE_IO:   begin dec.tgt = TGT_IO;   dec.off = raw & M_IO;   end
                CODE_PAL:  begin dec.tgt = TGT_PAL;  dec.off = raw & M_PAL;  end
                CODE_VRAM: begin dec.tgt = TGT_VRAM; dec.off = raw & M_VRAM; end
                CODE_OAM:  begin dec.tgt = TGT_OAM;  dec.off = raw & M_OAM;  end
                default:   dec.mapped = 1'b0;
            endcase
        end
    end

    assign boot_in_bounds = addr_in[23:0] < 24'(BOOT_BYTES);
    assign vram_byte_ok   = addr_in[23:0] < 24'(VRAM_BYTE_LIMIT);

endmodule

// File: rtl/brs_boot_latch.sv
module brs_boot_latch
    import brs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] pc_region,
    input  logic [DATA_W-1:0] fetch_word,
    output logic              pc_in_boot,
    output logic [DATA_W-1:0] latch_word
);

    logic [DATA_W-1:0] latch_q;

    assign pc_in_boot = (pc_region == CODE_BOOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
        end else if (pc_in_boot) begin
            latch_q <= fetch_word;
        end
    end

    assign latch_word = latch_q;

    // R7: outside the boot ROM the latched word must not move
    p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (pc_region != CODE_BOOT) |=> $stable(latch_word));

    // R7: inside the boot ROM the fetch word is taken on the edge
    p_latch_take_r7: assert property (@(posedge clk) disable iff (rst)
        (pc_region == CODE_BOOT) |=> (latch_word == $past(fetch_word)));

endmodule

// File: rtl/brs_read_align.sv
module brs_read_align
    import brs_pkg::*;
(
    input  decode_t           dec,
    input  acc_size_e         size,
    input  logic [1:0]        lo,
    input  logic              pc_in_boot,
    input  logic              boot_in_bounds,
    input  logic [DATA_W-1:0] latch_word,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [15:0]       io_lo,
    input  logic [15:0]       io_hi,
    input  logic [OFF_W:0]    rom_size,
    output logic [DATA_W-1:0] load_word,
    output logic              load_live
);

    logic [DATA_W-1:0] src;

    always_comb begin
        src       = '0;
        load_live = 1'b0;
        if (dec.mapped) begin
            case (dec.tgt)
                TGT_BOOT: begin
                    if (pc_in_boot) begin
                        load_live = boot_in_bounds;
                        src       = boot_in_bounds ? mem_rdata : '0;
                    end else begin
                        src = latch_word;
                    end
                end
                TGT_ROM: begin
                    load_live = {1'b0, dec.off} < rom_size;
                    src       = load_live ? mem_rdata : '0;
                end
                TGT_IO: begin
                    load_live = 1'b1;
                    src       = {io_hi, io_lo};
                end
                default: begin
                    load_live = 1'b1;
                    src       = mem_rdata;
                end
            endcase
        end
        load_word = load_extract(src, size, lo);
    end

endmodule

// File: rtl/brs_write_steer.sv
module brs_write_steer
    import brs_pkg::*;
(
    input  decode_t           dec,
    input  acc_size_e         size,
    input  logic [1:0]        lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              vram_byte_ok,
    output logic [LANES-1:0]  lane_we,
    output logic [DATA_W-1:0] store_data,
    output logic              store_live
);

    logic [LANES-1:0] base;
    logic             allow;

    always_comb begin
        base  = lane_mask(size, lo);
        allow = dec.mapped && (dec.tgt != TGT_BOOT) && (dec.tgt != TGT_ROM);
        if (size == SZ_BYTE) begin
            if (dec.tgt == TGT_OAM) begin
                allow = 1'b0;
            end else if (dec.tgt == TGT_VRAM) begin
                allow = allow && vram_byte_ok;
                base  = lo[1] ? 4'b1100 : 4'b0011;
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_we[g] = allow & base[g];
    end

    assign store_data = store_replicate(wdata, size);
    assign store_live = |lane_we;

endmodule

// File: rtl/bus_region_steer.sv
module bus_region_steer
    import brs_pkg::*;
#(
    parameter int BOOT_BYTES      = 16384,
    parameter int WRAM_BYTES      = 262144,
    parameter int IRAM_BYTES      = 32768,
    parameter int IO_BYTES        = 1024,
    parameter int PAL_BYTES       = 1024,
    parameter int VRAM_WINDOW     = 131072,
    parameter int OAM_BYTES       = 1024,
    parameter int VRAM_BYTE_LIMIT = 98304,
    localparam int IO_W           = $clog2(IO_BYTES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [1:0]          acc_size,
    input  logic                acc_write,
    input  logic [DATA_W-1:0]   acc_wdata,
    input  logic [CODE_W-1:0]   pc_region,
    input  logic [DATA_W-1:0]   boot_fetch_word,
    input  logic [OFF_W:0]      rom_size,
    input  logic [DATA_W-1:0]   mem_rdata,
    input  logic [15:0]         io_rdata_lo,
    input  logic [15:0]         io_rdata_hi,
    output logic [NUM_TGT-1:0]  region_sel,
    output logic [OFF_W-1:0]    region_off,
    output logic [IO_W-1:0]     io_off_lo,
    output logic [IO_W-1:0]     io_off_hi,
    output logic [LANES-1:0]    byte_we,
    output logic [DATA_W-1:0]   wr_data,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_err
);

    acc_size_e         size;
    decode_t           dec;
    logic              boot_in_bounds;
    logic              vram_byte_ok;
    logic              pc_in_boot;
    logic [DATA_W-1:0] latch_word;
    logic [DATA_W-1:0] load_word;
    logic              load_live;
    logic [LANES-1:0]  lane_we;
    logic              store_live;
    logic              unused_addr_hi;

    assign size           = acc_size_e'(acc_size);
    assign unused_addr_hi = ^acc_addr[31:28];

    brs_region_decode #(
        .BOOT_BYTES      (BOOT_BYTES),
        .WRAM_BYTES      (WRAM_BYTES),
        .IRAM_BYTES      (IRAM_BYTES),
        .IO_BYTES        (IO_BYTES),
        .PAL_BYTES       (PAL_BYTES),
        .VRAM_WINDOW     (VRAM_WINDOW),
        .OAM_BYTES       (OAM_BYTES),
        .VRAM_BYTE_LIMIT (VRAM_BYTE_LIMIT)
    ) u_decode (
        .addr_in        (acc_addr[27:0]),
        .dec            (dec),
        .boot_in_bounds (boot_in_bounds),
        .vram_byte_ok   (vram_byte_ok)
    );

    brs_boot_latch u_boot_latch (
        .clk        (clk),
        .rst        (rst),
        .pc_region  (pc_region),
        .fetch_word (boot_fetch_word),
        .pc_in_boot (pc_in_boot),
        .latch_word (latch_word)
    );

    brs_read_align u_read (
        .dec            (dec),
        .size           (size),
        .lo             (acc_addr[1:0]),
        .pc_in_boot     (pc_in_boot),
        .boot_in_bounds (boot_in_bounds),
        .latch_word     (latch_word),
        .mem_rdata      (mem_rdata),
        .io_lo          (io_rdata_lo),
        .io_hi          (io_rdata_hi),
        .rom_size       (rom_size),
        .load_word      (load_word),
        .load_live      (load_live)
    );

    brs_write_steer u_write (
        .dec          (dec),
        .size         (size),
        .lo           (acc_addr[1:0]),
        .wdata        (acc_wdata),
        .vram_byte_ok (vram_byte_ok),
        .lane_we      (lane_we),
        .store_data   (wr_data),
        .store_live   (store_live)
    );

    // One select line per target; a line is live only for an access that
    // really reaches memory.
    for (genvar t = 0; t < NUM_TGT; t++) begin : g_sel
        assign region_sel[t] = acc_valid && dec.mapped && (dec.tgt == tgt_e'(t)) &&
                               (acc_write ? store_live : load_live);
    end

    assign region_off = dec.mapped ? dec.off : '0;
    assign io_off_lo  = {dec.off[IO_W-1:2], 2'b00};
    assign io_off_hi  = {dec.off[IO_W-1:2], 2'b10};
    assign byte_we    = (acc_valid && acc_write) ? lane_we : '0;
    assign rd_data    = (acc_valid && !acc_write) ? load_word : '0;
    assign rd_err     = acc_valid && !acc_write && !dec.mapped;

    // R1: never more than one target at a time
    p_sel_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(region_sel));

    // R1: an idle bus drives nothing
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (region_sel == '0 && byte_we == '0));

    // R10: an error load touches no memory and returns zero
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        rd_err |-> (region_sel == '0 && rd_data == '0 && byte_we == '0));

    // R13: read-only images are never written
    p_ro_nowrite_r13: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && dec.mapped &&
         (dec.tgt == TGT_ROM || dec.tgt == TGT_BOOT)) |-> (byte_we == '0));

    // R12: a video RAM byte store fills a whole halfword or nothing
    p_vram_pair_r12: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && size == SZ_BYTE && dec.mapped &&
         dec.tgt == TGT_VRAM && byte_we != '0) |->
        ((byte_we == 4'b0011 || byte_we == 4'b1100) && wr_data[7:0] == wr_data[15:8]));

endmodule

// File: tb/test_bus_region_steer.sv
`timescale 1ns/1ps
module test_bus_region_steer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_write = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [3:0]  pc_region = 4'h7;
    logic [31:0] boot_fetch_word = 32'h0BAD_F00D;
    logic [25:0] rom_size = 26'h004_0000;
    logic [31:0] mem_rdata;
    logic [15:0] io_rdata_lo, io_rdata_hi;
    logic [7:0]  region_sel;
    logic [24:0] region_off;
    logic [9:0]  io_off_lo, io_off_hi;
    logic [3:0]  byte_we;
    logic [31:0] wr_data, rd_data;
    logic        rd_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [31:0] latch_exp = '0;

    always #5 clk = ~clk;

    bus_region_steer i_bus_region_steer (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_size(acc_size), .acc_write(acc_write), .acc_wdata(acc_wdata),
        .pc_region(pc_region), .boot_fetch_word(boot_fetch_word),
        .rom_size(rom_size), .mem_rdata(mem_rdata), .io_rdata_lo(io_rdata_lo),
        .io_rdata_hi(io_rdata_hi), .region_sel(region_sel), .region_off(region_off),
        .io_off_lo(io_off_lo), .io_off_hi(io_off_hi), .byte_we(byte_we),
        .wr_data(wr_data), .rd_data(rd_data), .rd_err(rd_err)
    );

    function automatic logic [31:0] pat(input int t, input logic [31:0] woff);
        logic [31:0] a;
        a = 32'(t + 1) * 32'h0100_0193;
        return (a ^ (woff * 32'h9E37_79B9)) + 32'h1234_5678;
    endfunction

    function automatic logic [15:0] pat16(input logic [31:0] o);
        logic [31:0] p;
        p = pat(3, o);
        return p[15:0];
    endfunction

    // behavioural memories
    always_comb begin
        mem_rdata = 32'hDEAD_BEEF;
        for (int t = 0; t < 8; t++)
            if (region_sel[t]) mem_rdata = pat(t, 32'(region_off >> 2));
        io_rdata_lo = pat16(32'(io_off_lo));
        io_rdata_hi = pat16(32'(io_off_hi));
    end

    function automatic int tgt_of(input logic [3:0] c);
        case (c)
            4'h0: return 0;
            4'h2: return 1;
            4'h3: return 2;
            4'h4: return 3;
            4'h5: return 4;
            4'h6: return 5;
            4'h7: return 6;
            4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD: return 7;
            default: return -1;
        endcase
    endfunction

    function automatic logic [24:0] mask_of(input int t);
        case (t)
            0: return 25'(16384 - 1);
            1: return 25'(262144 - 1);
            2: return 25'(32768 - 1);
            5: return 25'h1FFFF;
            7: return 25'h1FF_FFFF;
            default: return 25'(1024 - 1);
        endcase
    endfunction

    function automatic logic [31:0] shape(input logic [31:0] src, input int sz, input logic [1:0] lo);
        logic [63:0] d;
        logic [31:0] h;
        d = {src, src} >> (8 * lo);
        h = src >> (16 * lo[1]);
        if (sz == 0) return {24'b0, src[8*lo +: 8]};
        if (sz == 1) begin
            d = {h[15:0], h[15:0], h[15:0], h[15:0]} >> (8 * lo[0]);
            return {16'b0, d[15:0]};
        end
        return d[31:0];
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%h size=%0d wr=%0d actual=%h expected=%h",
                     tag, acc_addr, acc_size, acc_write, act, exp);
        end
    endtask

    task automatic do_access(input logic [31:0] a, input int sz, input bit wr, input logic [31:0] wd);
        int t;
        logic [24:0] off;
        logic [31:0] src, exp_d, exp_w;
        logic [7:0]  exp_sel;
        logic [3:0]  exp_be, base;
        bit live, allow;
        string tag;
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_size = 2'(sz); acc_write = wr; acc_wdata = wd;
        #2;
        t = tgt_of(a[27:24]);
        off = (t < 0) ? 25'd0 : (a[24:0] & mask_of(t));
        chk("R1 R2 select/offset", {24'b0, 8'(t < 0 ? 0 : 1), 7'b0, off},
            {24'b0, 8'(t < 0 ? 0 : 1), 7'b0, region_off});
        if (!wr) begin
            live = (t >= 0); src = 32'h0;
            if (t == 0) begin
                if (pc_region == 4'h0) begin
                    live = a[23:0] < 24'd16384;
                    src  = live ? pat(0, 32'(off >> 2)) : 32'h0;
                end else begin
                    live = 1'b0; src = latch_exp;
                end
            end else if (t == 7) begin
                live = {1'b0, off} < rom_size;
                src  = live ? pat(7, 32'(off >> 2)) : 32'h0;
            end else if (t == 3) begin
                src = {pat16(32'({off[9:2], 2'b10})), pat16(32'({off[9:2], 2'b00}))};
            end else if (t > 0) begin
                src = pat(t, 32'(off >> 2));
            end
            exp_d = shape(src, sz, a[1:0]);
            exp_sel = live ? (8'b1 << t) : 8'b0;
            if (t < 0)       tag = "R10";
            else if (t == 0) tag = "R6";
            else if (t == 7) tag = "R8";
            else if (t == 3) tag = "R9";
            else if (sz == 0) tag = "R5";
            else if (sz == 1) tag = "R4";
            else tag = "R3";
            chk({tag, " load data/err"}, {31'b0, rd_err, rd_data}, {31'b0, (t < 0), exp_d});
            chk({tag, " R1 load select"}, 64'(region_sel), 64'(exp_sel));
        end else begin
            base  = (sz == 0) ? (4'b0001 << a[1:0]) : (sz == 1) ? (a[1] ? 4'b1100 : 4'b0011) : 4'b1111;
            allow = (t > 0) && (t != 7);
            tag = "R11";
            if (t == 0 || t == 7 || t < 0) tag = (t < 0) ? "R10" : "R13";
            if (sz == 0 && t == 6) begin allow = 1'b0; tag = "R13"; end
            if (sz == 0 && t == 5) begin
                allow = allow && (a[23:0] < 24'h018000);
                base  = a[1] ? 4'b1100 : 4'b0011;
                tag   = "R12";
            end
            exp_be  = allow ? base : 4'b0;
            exp_sel = (exp_be != 0) ? (8'b1 << t) : 8'b0;
            exp_w   = (sz == 0) ? {4{wd[7:0]}} : (sz == 1) ? {2{wd[15:0]}} : wd;
            chk({tag, " lanes/select"}, {52'b0, exp_be, exp_sel}, {52'b0, byte_we, region_sel});
            chk("R11 store data", 64'(wr_data), 64'(exp_w));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [23:0] offs [4];
        offs = '{24'h000010, 24'h040124, 24'h017FFC, 24'h018000};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: reset/idle state
        chk("R1 idle outputs", {27'b0, rd_err, byte_we, region_sel[0]}, 64'b0);
        chk("R1 idle select", 64'(region_sel), 64'b0);
        // R7: reset clears the latch (pc outside boot since reset)
        latch_exp = 32'h0;
        do_access(32'h0000_0010, 2, 1'b0, 32'h0);

        pc_region = 4'h0;
        latch_exp = boot_fetch_word;
        for (int code = 0; code < 16; code++)
            for (int oi = 0; oi < 4; oi++)
                for (int lo = 0; lo < 4; lo++)
                    for (int sz = 0; sz < 3; sz++) begin
                        logic [31:0] a;
                        logic [31:0] wd;
                        a  = {(code[0] ? 4'hF : 4'h0), 4'(code), offs[oi] | 24'(lo)};
                        wd = 32'h5A3C_9600 ^ (32'(code) << 20) ^ (32'(oi) << 12) ^ 32'(lo * 37 + sz);
                        do_access(a, sz, 1'b0, 32'h0);
                        do_access(a, sz, 1'b1, wd);
                    end

        // R7: capture in boot, hold outside
        @(negedge clk); boot_fetch_word = 32'h1357_9BDF; pc_region = 4'h0;
        @(negedge clk); boot_fetch_word = 32'h2468_ACE0; pc_region = 4'h3;
        latch_exp = 32'h1357_9BDF;
        do_access(32'h0000_0011, 2, 1'b0, 32'h0);  // R6 R7 rotated latch word
        @(negedge clk); boot_fetch_word = 32'hFEDC_BA98;
        repeat (3) @(posedge clk);
        do_access(32'h0000_0103, 1, 1'b0, 32'h0);  // R7 held
        @(negedge clk); pc_region = 4'h0; boot_fetch_word = 32'hA5C3_1E2F;
        @(negedge clk); pc_region = 4'h6; boot_fetch_word = 32'h0;
        latch_exp = 32'hA5C3_1E2F;
        do_access(32'h0000_2002, 0, 1'b0, 32'h0);  // R7 new capture
        do_access(32'h0000_5000, 2, 1'b0, 32'h0);  // R6 beyond end, pc outside

        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b1; acc_addr = 32'h0200_0000;
        #2;
        chk("R1 idle write", {56'b0, byte_we, 3'b0, rd_err}, 64'b0);
        chk("R1 idle select", 64'(region_sel), 64'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule